// File: doc/BRIEF.md
# Read-Only Bus Cartridge RAM Writer

This block lets a processor store bytes into cartridge RAM over an address bus that has no write strobe and no usable data path toward the cartridge. The program reads an address in a trigger page. The low byte of that address becomes the byte to store. The block then watches the 13-bit bus. When the fifth distinct address value appears after the trigger, it issues one RAM write of the captured byte to that address. The write only happens if the address lies in the cartridge memory window and writing is enabled.

The count is based on changes in the address value, not on clock cycles. Repeated samples of the same address do not advance it, so the processor's dummy and repeated bus cycles do not disturb the timing. A control byte at a fixed address is loaded immediately with the captured byte, without any counting. One of its bits is the write enable for the delayed RAM write.

Top module: `cart_ram_writer`

## Requirements
- R1: After reset, `ramWe` is 0 and `ramAddr`, `ramData` and `ctrlReg` are all zero. Bit 1 of `ctrlReg` is the write enable, so writes start out disabled.
- R2: A new address in the trigger page 0x1000–0x10FF captures `busAddr[7:0]` as the pending byte. A later RAM write carries that byte on `ramData`.
- R3: The RAM write happens on the fifth distinct address after the trigger. `ramWe` and `ramAddr` show the result one clock after that address is sampled, and no write happens on the first four addresses.
- R4: A sample equal to the previous sample is not a change. It neither advances the count nor acts as a trigger or control access.
- R5: A delayed write whose fifth address has `busAddr[12]` = 0 (outside the cartridge window) is discarded. No later address writes it.
- R6: When bit 1 of `ctrlReg` is 0, the fifth address discards the pending byte without asserting `ramWe`.
- R7: A new address equal to 0x1FF8 loads the captured byte into `ctrlReg` one clock later. This does not depend on the enable bit or on any count. It also cancels a pending write.
- R8: A trigger-page access while a write is pending restarts the count from zero and replaces the pending byte with the new one.
- R9: `ramWe` is high for exactly one clock per write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; `busAddr` is sampled on each rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 13 | Cartridge address bus A12..A0 |
| ramWe | output | 1 | One-clock RAM write strobe |
| ramAddr | output | 13 | Address for the RAM write |
| ramData | output | 8 | Byte for the RAM write |
| ctrlReg | output | 8 | Control register; bit 1 enables RAM writes |

## Verification
A wrong count shows up as `ramWe` firing one address too early or too late. Any drift becomes visible within the five addresses that follow a trigger. If the change detector wrongly counted repeated samples, repeated addresses placed mid-sequence would pull the write forward, and the repeated-address vectors catch this at once. A stale pending flag, or one that failed to cancel, shows up as a spurious write after a control access or after a discarded write. A lost enable bit shows up as missing or extra strobes on the next sequence.

// File: rtl/cart_writer_pkg.sv
package cart_writer_pkg;

  // Strobes from the sequencer to the datapath, one bus sample at a time.
  typedef struct packed {
    logic latchData;   // capture low address byte as pending data
    logic loadCtrl;    // copy pending data into the control register
    logic issueWrite;  // emit a RAM write at the current address
  } strobe_t;

endpackage

// File: rtl/cart_writer_dp.sv
module cart_writer_dp
  import cart_writer_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 8,
  parameter int TRIG_HI   = 'h10,
  parameter int CTRL_ADDR = 'h1FF8,
  parameter int WIN_BIT   = 12,
  parameter int WEN_BIT   = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  strobe_t           stb,
  output logic              isChange,
  output logic              isTrig,
  output logic              isCtrl,
  output logic              inWindow,
  output logic              wrEn,
  output logic              ramWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramData,
  output logic [DATA_W-1:0] ctrlReg
);

  localparam int HI_W = ADDR_W - DATA_W;
  localparam logic [HI_W-1:0]   TRIG_PAGE = HI_W'(TRIG_HI);
  localparam logic [ADDR_W-1:0] CTRL_A    = ADDR_W'(CTRL_ADDR);

  logic [ADDR_W-1:0] prevAddr;
  logic              seenAny;
  logic [DATA_W-1:0] pendData;

  // Change detection: first sample after reset always counts as new.
  always_comb begin
    isChange = !seenAny || (busAddr != prevAddr);
    isTrig   = (busAddr[ADDR_W-1:DATA_W] == TRIG_PAGE);
    isCtrl   = (busAddr == CTRL_A);
    inWindow = busAddr[WIN_BIT];
    wrEn     = ctrlReg[WEN_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevAddr <= '0;
      seenAny  <= 1'b0;
    end else begin
      prevAddr <= busAddr;
      seenAny  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendData <= '0;
    end else if (stb.latchData) begin
      pendData <= busAddr[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else if (stb.loadCtrl) begin
      ctrlReg <= pendData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ramWe   <= 1'b0;
      ramAddr <= '0;
      ramData <= '0;
    end else begin
      ramWe <= stb.issueWrite;
      if (stb.issueWrite) begin
        ramAddr <= busAddr;
        ramData <= pendData;
      end
    end
  end

  AST_WE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |=> !ramWe); // R9
  AST_WE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> ramAddr[WIN_BIT]); // R5
  AST_WE_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> ctrlReg[WEN_BIT]); // R6
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadCtrl |=> $stable(ctrlReg)); // R7

endmodule

// File: rtl/cart_writer_seq.sv
module cart_writer_seq
  import cart_writer_pkg::*;
#(
  parameter int DELAY = 5
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    isChange,
  input  logic    isTrig,
  input  logic    isCtrl,
  input  logic    inWindow,
  input  logic    wrEn,
  output strobe_t stb
);

  localparam int CNT_W = (DELAY > 1) ? $clog2(DELAY) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY - 1);

  logic             pending;
  logic [CNT_W-1:0] cnt;
  logic             atLast;

  assign atLast = pending && (cnt == LAST);

  // Trigger page wins over all else; control byte cancels; otherwise count.
  always_comb begin
    stb = '0;
    if (isChange) begin
      if (isTrig) begin
        stb.latchData = 1'b1;
      end else if (isCtrl) begin
        stb.loadCtrl = 1'b1;
      end else if (atLast) begin
        stb.issueWrite = inWindow && wrEn;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
      cnt     <= '0;
    end else if (isChange) begin
      if (isTrig) begin
        pending <= 1'b1;
        cnt     <= '0;
      end else if (isCtrl || atLast) begin
        pending <= 1'b0;
        cnt     <= '0;
      end else if (pending) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= LAST); // R3
  AST_REPEAT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !isChange |=> $stable(cnt) && $stable(pending)); // R4
  AST_TRIG_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (isChange && isTrig) |=> pending && cnt == '0); // R8
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !pending |-> !stb.issueWrite); // R5

endmodule

// File: rtl/cart_ram_writer.sv
module cart_ram_writer
  import cart_writer_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 8,
  parameter int DELAY     = 5,
  parameter int TRIG_HI   = 'h10,
  parameter int CTRL_ADDR = 'h1FF8,
  parameter int WIN_BIT   = 12,
  parameter int WEN_BIT   = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  output logic              ramWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramData,
  output logic [DATA_W-1:0] ctrlReg
);

  strobe_t stb;
  logic    isChange;
  logic    isTrig;
  logic    isCtrl;
  logic    inWindow;
  logic    wrEn;

  cart_writer_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TRIG_HI(TRIG_HI),
    .CTRL_ADDR(CTRL_ADDR), .WIN_BIT(WIN_BIT), .WEN_BIT(WEN_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .stb(stb),
    .isChange(isChange), .isTrig(isTrig), .isCtrl(isCtrl),
    .inWindow(inWindow), .wrEn(wrEn),
    .ramWe(ramWe), .ramAddr(ramAddr), .ramData(ramData), .ctrlReg(ctrlReg)
  );

  cart_writer_seq #(
    .DELAY(DELAY)
  ) u_seq (
    .clk(clk), .rstN(rstN), .isChange(isChange), .isTrig(isTrig),
    .isCtrl(isCtrl), .inWindow(inWindow), .wrEn(wrEn), .stb(stb)
  );

endmodule

// File: tb/cart_ram_writer_tb.sv
module cart_ram_writer_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [12:0] busAddr = '0;
  logic        ramWe;
  logic [12:0] ramAddr;
  logic [7:0]  ramData;
  logic [7:0]  ctrlReg;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  cart_ram_writer u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr),
    .ramWe(ramWe), .ramAddr(ramAddr), .ramData(ramData), .ctrlReg(ctrlReg)
  );

  // {address, expected strobe, expected data}; ctrlReg starts at 0.
  localparam int NV = 25;
  localparam logic [21:0] VEC [NV] = '{
    {13'h1002, 1'b0, 8'h00},  // trigger, byte 02
    {13'h1FF8, 1'b0, 8'h00},  // control <= 02 (enable)
    {13'h10E7, 1'b0, 8'h00},  // trigger, byte E7
    {13'h1200, 1'b0, 8'h00},  // 1
    {13'h1200, 1'b0, 8'h00},  // repeat, no count
    {13'h0300, 1'b0, 8'h00},  // 2
    {13'h1201, 1'b0, 8'h00},  // 3
    {13'h1202, 1'b0, 8'h00},  // 4
    {13'h1203, 1'b1, 8'hE7},  // 5 -> write
    {13'h1204, 1'b0, 8'h00},  // strobe ends
    {13'h1055, 1'b0, 8'h00},  // trigger 55
    {13'h1300, 1'b0, 8'h00},  // 1
    {13'h10AA, 1'b0, 8'h00},  // retrigger AA (R8)
    {13'h1301, 1'b0, 8'h00},
    {13'h1302, 1'b0, 8'h00},
    {13'h1303, 1'b0, 8'h00},
    {13'h1304, 1'b0, 8'h00},
    {13'h1305, 1'b1, 8'hAA},  // fifth after retrigger
    {13'h1011, 1'b0, 8'h00},  // trigger 11
    {13'h0001, 1'b0, 8'h00},
    {13'h0002, 1'b0, 8'h00},
    {13'h0003, 1'b0, 8'h00},
    {13'h0004, 1'b0, 8'h00},
    {13'h0005, 1'b0, 8'h00},  // fifth outside window (R5)
    {13'h1400, 1'b0, 8'h00}   // nothing left pending
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Drive at the falling edge, check just after the next rising edge.
  task automatic step(input logic [12:0] a, input bit expWe,
                      input logic [7:0] expData, input string tag);
    @(negedge clk);
    busAddr = a;
    @(posedge clk);
    #1;
    chk(ramWe == expWe, tag, 32'(ramWe), 32'(expWe));
    if (expWe) begin
      chk(ramData == expData, tag, 32'(ramData), 32'(expData));
      chk(ramAddr == a, tag, 32'(ramAddr), 32'(a));
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(ramWe == 1'b0, "R1", 32'(ramWe), 0);
    chk(ctrlReg == 8'h00, "R1", 32'(ctrlReg), 0);
    chk(ramData == 8'h00, "R1", 32'(ramData), 0);
    chk(ramAddr == 13'h0, "R1", 32'(ramAddr), 0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string tag;
      if (i == 9)                 tag = "R9";
      else if (i >= 12 && i <= 17) tag = "R8";
      else if (i >= 19)           tag = "R5";
      else if (i == 4)            tag = "R4";
      else if (VEC[i][8])         tag = "R2 R3";
      else                        tag = "R3";
      step(VEC[i][21:9], VEC[i][8], VEC[i][7:0], tag);
    end
    chk(ctrlReg == 8'h02, "R7", 32'(ctrlReg), 32'h02);

    // R6: clear the enable, then a full sequence must not write
    step(13'h1000, 1'b0, 8'h00, "R6");
    step(13'h1FF8, 1'b0, 8'h00, "R6");
    chk(ctrlReg == 8'h00, "R7", 32'(ctrlReg), 0);
    step(13'h1033, 1'b0, 8'h00, "R6");
    for (int k = 0; k < 6; k++) step(13'h1500 + 13'(k), 1'b0, 8'h00, "R6");
    chk(ctrlReg == 8'h00, "R6", 32'(ctrlReg), 0);

    // R7: control loads while disabled, and cancels a pending write
    step(13'h1002, 1'b0, 8'h00, "R7");
    step(13'h1FF8, 1'b0, 8'h00, "R7");
    chk(ctrlReg == 8'h02, "R7", 32'(ctrlReg), 32'h02);
    step(13'h1077, 1'b0, 8'h00, "R7");
    step(13'h1600, 1'b0, 8'h00, "R7");
    step(13'h1601, 1'b0, 8'h00, "R7");
    step(13'h1FF8, 1'b0, 8'h00, "R7");
    chk(ctrlReg == 8'h77, "R7", 32'(ctrlReg), 32'h77);
    for (int k = 0; k < 5; k++) step(13'h1602 + 13'(k), 1'b0, 8'h00, "R7");

    // R4: repeats in mid-sequence do not count
    step(13'h1019, 1'b0, 8'h00, "R4");
    step(13'h1700, 1'b0, 8'h00, "R4");
    step(13'h1700, 1'b0, 8'h00, "R4");
    step(13'h1700, 1'b0, 8'h00, "R4");
    step(13'h1701, 1'b0, 8'h00, "R4");
    step(13'h1702, 1'b0, 8'h00, "R4");
    step(13'h1703, 1'b0, 8'h00, "R4");
    step(13'h1704, 1'b1, 8'h19, "R4");
    step(13'h1704, 1'b0, 8'h00, "R9");

    finish_run();
  end

endmodule